// File: doc/BRIEF.md
# Memory Chip-Enable Gate with Write Completion

This block sits between a processor's memory chip-enable (active low) and a battery-backed static RAM. While the system supervisor reports that the processor is out of reset, the incoming chip-enable passes straight through to the memory. When the supervisor flags reset, the path to memory is shut, so that a processor running on a failing supply cannot corrupt stored data.

Shutting the path in the middle of a write would itself corrupt a word. So, if reset is flagged while an access is in flight (chip-enable low), the block holds the gate open for a bounded grace window, counted in clock cycles. The gate shuts as soon as the access ends or when the window runs out, whichever comes first. Once shut, the output stays inactive (high) whatever the input does, until the supervisor releases reset and the input is idle high. The gate then reopens, so the memory never sees a partial access. A status output reports whether the gate is open.

The control is an explicit three-state machine (open, grace, closed) that is also held closed by the synchronous system reset. The output path is combinational, so chip-enable sees no clock latency while the gate is open.

Top module: `ce_gate_guard`

## Requirements
- R1: With the gate open and the reset flag low, `ce_out_n` equals `ce_in_n` in the same cycle, for any input pattern, and `gate_open` is 1.
- R2: If the reset flag is high and `ce_in_n` is 0 at a clock edge while the gate is open, the gate enters the grace window: `gate_open` stays 1 and `ce_out_n` keeps following `ce_in_n`.
- R3: If `ce_in_n` goes high during the grace window, `ce_out_n` goes high in the same cycle, and `gate_open` reads 0 after the next clock edge.
- R4: If `ce_in_n` stays low, the grace window lasts exactly `GRACE_CYC` clock edges after the edge that entered it. After that, `gate_open` reads 0 and `ce_out_n` reads 1.
- R5: While `gate_open` is 0, `ce_out_n` is 1 whatever the value of `ce_in_n`.
- R6: If the reset flag is high and `ce_in_n` is 1 at a clock edge while the gate is open, the gate closes at that edge and no grace window is started.
- R7: A closed gate reopens only at a clock edge where the reset flag is low and `ce_in_n` is 1. A low input or a high reset flag keeps it closed.
- R8: While `rst_n` is low at a clock edge, the gate is closed: `gate_open` is 0 and `ce_out_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset; closes the gate |
| sys_in_reset | input | 1 | High while the supervisor holds the processor in reset |
| ce_in_n | input | 1 | Chip-enable from the processor, active low |
| ce_out_n | output | 1 | Gated chip-enable to the memory, active low |
| gate_open | output | 1 | 1 while chip-enable may pass (open or grace) |

## Verification
The hardest situations to reach are the edges of the grace window: an access that ends one cycle before the window would expire, and one that is still low at the exact edge of expiry. The bench uses a small window and sweeps the cycle at which chip-enable is raised, from the entry edge through two cycles past expiry. On every pass it checks the open/closed status cycle by cycle against the arithmetic boundary. It then checks that the output stays high when the input falls again, and that reopening waits for an idle-high input after the reset flag is released.

// File: rtl/ce_gate_pkg.sv
// Package: shared types for the chip-enable gate.
// Assumes: nothing beyond IEEE 1800-2017.
package ce_gate_pkg;

    // Gate control states: passing, finishing an access, blocked.
    typedef enum logic [1:0] {
        GATE_OPEN   = 2'd0,
        GATE_GRACE  = 2'd1,
        GATE_CLOSED = 2'd2
    } gate_state_t;

endpackage

// File: rtl/ce_gate_timer.sv
// Module: grace-window counter.
// Counts clock edges spent in the grace window and flags the last one.
// Assumes: start and run are never high together; GRACE_CYC >= 1.
module ce_gate_timer #(
    parameter int GRACE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = (GRACE_CYC > 1) ? $clog2(GRACE_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GRACE_CYC - 1);

    logic [CNT_W-1:0] cnt;

    // Clear on window entry, advance while the window runs, hold at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (run && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Last edge of the window reached.
    always_comb begin
        expired = (cnt == LAST);
    end

    // R4
    cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R4
    cnt_cleared_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt == '0));

endmodule

// File: rtl/ce_gate_fsm.sv
// Module: gate control state machine.
// Decides, edge by edge, whether chip-enable may reach the memory.
// Assumes: sys_in_reset and ce_in_n are synchronous to clk.
module ce_gate_fsm
    import ce_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sys_in_reset,
    input  logic        ce_in_n,
    input  logic        win_expired,
    output logic        win_start,
    output logic        win_run,
    output gate_state_t state
);
    gate_state_t state_nx;

    // Next-state decision for the open/grace/closed machine.
    always_comb begin
        state_nx = state;
        unique case (state)
            GATE_OPEN: begin
                if (sys_in_reset) begin
                    state_nx = ce_in_n ? GATE_CLOSED : GATE_GRACE;
                end
            end
            GATE_GRACE: begin
                if (ce_in_n || win_expired) begin
                    state_nx = GATE_CLOSED;
                end
            end
            GATE_CLOSED: begin
                if (!sys_in_reset && ce_in_n) begin
                    state_nx = GATE_OPEN;
                end
            end
            default: state_nx = GATE_CLOSED;
        endcase
    end

    // State register; system reset leaves the gate closed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= GATE_CLOSED;
        end else begin
            state <= state_nx;
        end
    end

    // Timer control derived from the machine.
    always_comb begin
        win_start = (state == GATE_OPEN) && (state_nx == GATE_GRACE);
        win_run   = (state == GATE_GRACE);
    end

    // R2
    grace_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GATE_OPEN && sys_in_reset && !ce_in_n) |=> (state == GATE_GRACE));

    // R3
    grace_end_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GATE_GRACE && ce_in_n) |=> (state == GATE_CLOSED));

    // R6
    idle_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GATE_OPEN && sys_in_reset && ce_in_n) |=> (state == GATE_CLOSED));

    // R7
    reopen_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GATE_OPEN && $past(state) == GATE_CLOSED)
            |-> ($past(ce_in_n) && !$past(sys_in_reset)));

endmodule

// File: rtl/ce_gate_path.sv
// Module: chip-enable output stage.
// Passes chip-enable while the gate is open or in grace, forces it high otherwise.
// Assumes: the path is combinational; no clock latency on chip-enable.
module ce_gate_path
    import ce_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  gate_state_t state,
    input  logic        ce_in_n,
    output logic        ce_out_n,
    output logic        gate_open
);
    // Output select from the control state.
    always_comb begin
        gate_open = (state == GATE_OPEN) || (state == GATE_GRACE);
        ce_out_n  = gate_open ? ce_in_n : 1'b1;
    end

    // R5
    closed_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_open |-> ce_out_n);

    // R1
    open_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GATE_OPEN) |-> (ce_out_n == ce_in_n));

endmodule

// File: rtl/ce_gate_guard.sv
// Module: top of the memory chip-enable gate with write completion.
// Blocks chip-enable while the processor is in reset, finishing an in-flight
// access for at most GRACE_CYC clock edges.
// Assumes: synchronous active-low rst_n; sys_in_reset is synchronous to clk.
module ce_gate_guard #(
    parameter int GRACE_CYC = 4500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_in_reset,
    input  logic ce_in_n,
    output logic ce_out_n,
    output logic gate_open
);
    import ce_gate_pkg::*;

    gate_state_t state;
    logic        win_start;
    logic        win_run;
    logic        win_expired;

    ce_gate_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sys_in_reset (sys_in_reset),
        .ce_in_n      (ce_in_n),
        .win_expired  (win_expired),
        .win_start    (win_start),
        .win_run      (win_run),
        .state        (state)
    );

    ce_gate_timer #(
        .GRACE_CYC (GRACE_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (win_start),
        .run     (win_run),
        .expired (win_expired)
    );

    ce_gate_path u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .ce_in_n   (ce_in_n),
        .ce_out_n  (ce_out_n),
        .gate_open (gate_open)
    );

    // R8
    reset_closed_chk: assert property (@(posedge clk)
        !rst_n |=> (!gate_open && ce_out_n));

endmodule

// File: tb/ce_gate_guard_tb.sv
// Bench: sweeps the grace window edges of ce_gate_guard with a small window.
module ce_gate_guard_tb;
    localparam int G = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_in_reset = 1'b1;
    logic ce_in_n = 1'b1;
    logic ce_out_n;
    logic gate_open;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    ce_gate_guard #(.GRACE_CYC(G)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sys_in_reset (sys_in_reset),
        .ce_in_n      (ce_in_n),
        .ce_out_n     (ce_out_n),
        .gate_open    (gate_open)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Bring the gate to open with an idle input and the reset flag low.
    task automatic reopen();
        sys_in_reset = 1'b0;
        ce_in_n = 1'b1;
        tick();
        check("R7 reopen", gate_open, 1'b1);
    endtask

    initial begin
        // R8: system reset closes the gate.
        repeat (3) tick();
        check("R8 gate_open", gate_open, 1'b0);
        check("R8 ce_out_n", ce_out_n, 1'b1);
        rst_n = 1'b1;
        // R5/R7: reset flag high keeps it closed whatever the input does.
        ce_in_n = 1'b0; #1;
        check("R5 out high closed", ce_out_n, 1'b1);
        tick();
        check("R7 closed flag high", gate_open, 1'b0);
        ce_in_n = 1'b1;
        tick();
        check("R7 closed flag high idle", gate_open, 1'b0);
        // R7: flag low but input low: no reopen.
        sys_in_reset = 1'b0;
        ce_in_n = 1'b0;
        tick();
        check("R7 no reopen on low", gate_open, 1'b0);
        check("R5 out high", ce_out_n, 1'b1);
        reopen();

        // R1: output follows input over a pattern sweep.
        for (int i = 0; i < 32; i++) begin
            ce_in_n = logic'((i ^ (i >> 2)) & 1);
            #1;
            check("R1 follow", ce_out_n, ce_in_n);
            tick();
            check("R1 open", gate_open, 1'b1);
        end

        // R6: idle input when reset flag rises closes at once.
        ce_in_n = 1'b1;
        sys_in_reset = 1'b1;
        tick();
        check("R6 closed at once", gate_open, 1'b0);
        ce_in_n = 1'b0; #1;
        check("R6 R5 out high", ce_out_n, 1'b1);
        reopen();

        // R2/R3/R4: sweep the cycle at which the access ends.
        for (int k = 0; k <= G + 2; k++) begin
            ce_in_n = 1'b0;
            tick();
            sys_in_reset = 1'b1;
            tick();
            check("R2 grace open", gate_open, 1'b1);
            check("R2 grace follow", ce_out_n, 1'b0);
            for (int j = 1; j <= k; j++) begin
                tick();
                check("R4 window edge", gate_open, logic'(j < G));
                check("R4 out", ce_out_n, logic'(j >= G));
            end
            ce_in_n = 1'b1; #1;
            check("R3 out high same cycle", ce_out_n, 1'b1);
            tick();
            check("R3 closed after idle", gate_open, 1'b0);
            ce_in_n = 1'b0; #1;
            check("R5 stays high", ce_out_n, 1'b1);
            sys_in_reset = 1'b0;
            tick();
            check("R7 wait for idle", gate_open, 1'b0);
            check("R5 out high", ce_out_n, 1'b1);
            reopen();
            ce_in_n = 1'b0; #1;
            check("R1 after reopen", ce_out_n, 1'b0);
        end

        // R8: system reset during grace closes the gate.
        ce_in_n = 1'b0;
        sys_in_reset = 1'b1;
        tick();
        rst_n = 1'b0;
        tick();
        check("R8 mid grace", gate_open, 1'b0);
        check("R8 out", ce_out_n, 1'b1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule